// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block manages two low-power states of a small processor core on a single clock domain. A control register written by the core holds an idle bit, a power-down bit and a pair of general-purpose flag bits. In idle, the core's clock enable drops while the interrupt, timer and serial-port enables keep running. In power-down, every enable drops, so all state is frozen in place.

Idle ends on its own when an enabled interrupt is pending: the idle bit clears and the core resumes. Because the core's registers were only held and never cleared, execution continues where it stopped. Power-down ends only through the active-low reset, which also ends idle at once, without waiting for a clock edge. While a mode is active, the block also takes over the address-latch strobe, the program-fetch strobe and the port 0 / port 2 drive selection, so that the external bus pins sit at defined levels.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, ctrl_o reads 0, cpu_ce_o is 1, every periph_ce_o bit is 1, ale_o/psen_o follow ale_i/psen_i, and p0_float_o and p2_addr_o are 0.
- R2: A write with bit 0 set and bit 1 clear enters idle on that clock edge. ctrl_o bit 0 reads 1, cpu_ce_o is 0 and every periph_ce_o bit stays 1.
- R3: A write with bit 1 set enters power-down on that clock edge. ctrl_o bit 1 reads 1, and cpu_ce_o and every periph_ce_o bit are 0.
- R4: A write with both bit 0 and bit 1 set enters power-down only. ctrl_o reads bit 1 = 1 and bit 0 = 0.
- R5: In idle, irq_pending_i high at a clock edge clears the idle bit on that edge, which restores cpu_ce_o to 1.
- R6: In power-down, irq_pending_i has no effect. The register and all enables stay unchanged.
- R7: While idle or power-down is active, writes are ignored and ctrl_o is unchanged.
- R8: rst_ni going low clears idle or power-down immediately, without a clock edge. cpu_ce_o returns to 1 before the next rising clock.
- R9: ale_o and psen_o follow ale_i and psen_i in run, are forced to 1 in idle, and are forced to 0 in power-down.
- R10: With ext_mem_i high, p0_float_o is 1 in idle and in power-down. p2_addr_o is 1 only in idle with ext_mem_i high. Both are 0 in run.
- R11: Flag bits ctrl_o[FLAG_W+1:2] take wr_data_i[FLAG_W+1:2] on a run-mode write. They keep their value through idle entry and through wake-up by interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | FLAG_W+2 | Write data: bit 0 idle, bit 1 power-down, upper bits flags |
| irq_pending_i | input | 1 | An enabled interrupt is pending |
| ext_mem_i | input | 1 | Core is running from external memory |
| ale_i | input | 1 | Address-latch strobe from the core |
| psen_i | input | 1 | Program-fetch strobe from the core |
| ctrl_o | output | FLAG_W+2 | Control register contents |
| cpu_ce_o | output | 1 | Core clock enable |
| periph_ce_o | output | NUM_PERIPH | Interrupt/timer/serial clock enables |
| ale_o | output | 1 | Address-latch strobe to the pin |
| psen_o | output | 1 | Program-fetch strobe to the pin |
| p0_float_o | output | 1 | Release port 0 drivers |
| p2_addr_o | output | 1 | Port 2 holds the last address instead of latch data |

## Verification
On every cycle, the assertions check four things. Power-down survives a pending interrupt. A pending interrupt in idle wakes the core on the next edge. Register contents hold steady against writes while a mode is active. The strobe and enable outputs stay consistent with each other. Only the bench's scenarios can show the rest: the exact register values after each write pattern, the priority of power-down when both mode bits are written, the pin selection with internal and external memory, and the clearing of a mode by reset partway through a clock cycle.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

  localparam int IDLE_BIT  = 0;
  localparam int PDOWN_BIT = 1;
  localparam int FLAG_LSB  = 2;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
  import pwr_pkg::*;
#(
  parameter int FLAG_W = 2,
  localparam int CTRL_W = FLAG_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              irq_pending_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output pwr_mode_e         mode_o
);
  logic              idle_q, pd_q;
  logic [FLAG_W-1:0] flags_q;
  logic              run;

  assign run = !idle_q && !pd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q  <= 1'b0;
      pd_q    <= 1'b0;
      flags_q <= '0;
    end else if (run && wr_en_i) begin
      flags_q <= wr_data_i[FLAG_LSB +: FLAG_W];
      pd_q    <= wr_data_i[PDOWN_BIT];
      // power-down wins when both mode bits are written
      idle_q  <= wr_data_i[IDLE_BIT] && !wr_data_i[PDOWN_BIT];
    end else if (idle_q && irq_pending_i) begin
      idle_q <= 1'b0;
    end
  end

  assign ctrl_o = {flags_q, pd_q, idle_q};
  assign mode_o = pd_q ? MODE_PDOWN : (idle_q ? MODE_IDLE : MODE_RUN);

  AST_PD_HOLDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_q && irq_pending_i) |=> pd_q); // R6
  AST_IDLE_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q && irq_pending_i) |=> !idle_q); // R5
  AST_WR_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && wr_en_i && !irq_pending_i) |=> $stable(ctrl_o)); // R7
  AST_FLAGS_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run) |=> $stable(flags_q)); // R11
  AST_MODE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(idle_q && pd_q)); // R4
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
#(
  parameter int NUM_PERIPH = 3
) (
  input  pwr_mode_e             mode_i,
  output logic                  cpu_ce_o,
  output logic [NUM_PERIPH-1:0] periph_ce_o
);
  assign cpu_ce_o = (mode_i == MODE_RUN);

  for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_periph
    assign periph_ce_o[g] = (mode_i != MODE_PDOWN);
  end
endmodule

// File: rtl/pwr_pin_force.sv
module pwr_pin_force
  import pwr_pkg::*;
(
  input  pwr_mode_e mode_i,
  input  logic      ext_mem_i,
  input  logic      ale_i,
  input  logic      psen_i,
  output logic      ale_o,
  output logic      psen_o,
  output logic      p0_float_o,
  output logic      p2_addr_o
);
  always_comb begin
    ale_o      = ale_i;
    psen_o     = psen_i;
    p0_float_o = 1'b0;
    p2_addr_o  = 1'b0;
    unique case (mode_i)
      MODE_IDLE: begin
        ale_o      = 1'b1;
        psen_o     = 1'b1;
        p0_float_o = ext_mem_i;
        p2_addr_o  = ext_mem_i;
      end
      MODE_PDOWN: begin
        ale_o      = 1'b0;
        psen_o     = 1'b0;
        p0_float_o = ext_mem_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
#(
  parameter int FLAG_W = 2,
  parameter int NUM_PERIPH = 3,
  localparam int CTRL_W = FLAG_W + 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [CTRL_W-1:0]     wr_data_i,
  input  logic                  irq_pending_i,
  input  logic                  ext_mem_i,
  input  logic                  ale_i,
  input  logic                  psen_i,
  output logic [CTRL_W-1:0]     ctrl_o,
  output logic                  cpu_ce_o,
  output logic [NUM_PERIPH-1:0] periph_ce_o,
  output logic                  ale_o,
  output logic                  psen_o,
  output logic                  p0_float_o,
  output logic                  p2_addr_o
);
  pwr_mode_e mode;

  pwr_ctrl_reg #(.FLAG_W(FLAG_W)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .irq_pending_i,
    .ctrl_o, .mode_o(mode)
  );

  pwr_clk_gate #(.NUM_PERIPH(NUM_PERIPH)) u_gate (
    .mode_i(mode), .cpu_ce_o, .periph_ce_o
  );

  pwr_pin_force u_pins (
    .mode_i(mode), .ext_mem_i, .ale_i, .psen_i,
    .ale_o, .psen_o, .p0_float_o, .p2_addr_o
  );

  AST_CPU_NEEDS_PERIPH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ce_o |-> (&periph_ce_o)); // R3
  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_ce_o && (&periph_ce_o)) |-> (ale_o && psen_o)); // R9
  AST_PD_STROBES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_ce_o == '0) |-> (!ale_o && !psen_o)); // R9
  AST_RUN_NO_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_ce_o |-> (!p0_float_o && !p2_addr_o)); // R10
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] wr_data_i = '0;
  logic       irq_pending_i = 1'b0;
  logic       ext_mem_i = 1'b0;
  logic       ale_i = 1'b0;
  logic       psen_i = 1'b0;
  logic [3:0] ctrl_o;
  logic       cpu_ce_o;
  logic [2:0] periph_ce_o;
  logic       ale_o, psen_o, p0_float_o, p2_addr_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  pwr_mode_ctrl uut (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i, .irq_pending_i, .ext_mem_i,
    .ale_i, .psen_i, .ctrl_o, .cpu_ce_o, .periph_ce_o,
    .ale_o, .psen_o, .p0_float_o, .p2_addr_o
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic irq_pulse(input int n);
    @(negedge clk_i);
    irq_pending_i = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk_i);
    irq_pending_i = 1'b0;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; ale_i = 1'b1; psen_i = 1'b0; ext_mem_i = 1'b1;
    #1;
    check("R1 ctrl", ctrl_o, 0);
    check("R1 cpu_ce", cpu_ce_o, 1);
    check("R1 periph_ce", periph_ce_o, 3'b111);
    check("R1 ale", ale_o, 1);
    check("R1 psen", psen_o, 0);
    check("R1 p0/p2", {p0_float_o, p2_addr_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    ext_mem_i = 1'b0;
  endtask

  task automatic t_idle_wake;
    ale_i = 1'b0; psen_i = 1'b0; ext_mem_i = 1'b0;
    wr(4'b0001);
    check("R2 ctrl", ctrl_o, 4'b0001);
    check("R2 cpu_ce", cpu_ce_o, 0);
    check("R2 periph_ce", periph_ce_o, 3'b111);
    check("R9 idle strobes", {ale_o, psen_o}, 2'b11);
    check("R10 idle internal", {p0_float_o, p2_addr_o}, 0);
    ext_mem_i = 1'b1; #1;
    check("R10 idle external", {p0_float_o, p2_addr_o}, 2'b11);
    irq_pulse(1);
    check("R5 woke ctrl", ctrl_o, 0);
    check("R5 cpu_ce", cpu_ce_o, 1);
  endtask

  task automatic t_flags_locked;
    wr(4'b1000);
    check("R11 flags written", ctrl_o, 4'b1000);
    wr(4'b1001);
    check("R11 idle with flags", ctrl_o, 4'b1001);
    wr(4'b0110);
    check("R7 write in idle", ctrl_o, 4'b1001);
    irq_pulse(1);
    check("R11 flags after wake", ctrl_o, 4'b1000);
  endtask

  task automatic t_pdown;
    ale_i = 1'b1; psen_i = 1'b1; ext_mem_i = 1'b1;
    wr(4'b0110);
    check("R3 ctrl", ctrl_o, 4'b0110);
    check("R3 enables", {cpu_ce_o, periph_ce_o}, 0);
    check("R9 pd strobes", {ale_o, psen_o}, 0);
    check("R10 pd external", {p0_float_o, p2_addr_o}, 2'b10);
    irq_pulse(2);
    check("R6 irq in pd", ctrl_o, 4'b0110);
    check("R6 enables", {cpu_ce_o, periph_ce_o}, 0);
    wr(4'b0000);
    check("R7 write in pd", ctrl_o, 4'b0110);
    @(negedge clk_i); #2;
    rst_ni = 1'b0; #1;
    check("R8 pd async exit ctrl", ctrl_o, 0);
    check("R8 pd async cpu_ce", cpu_ce_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_both;
    wr(4'b0011);
    check("R4 both bits", ctrl_o, 4'b0010);
    check("R4 periph off", periph_ce_o, 0);
    @(negedge clk_i); #2;
    rst_ni = 1'b0; #1;
    check("R8 exit", ctrl_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_idle_reset;
    wr(4'b0001);
    check("R2 idle again", cpu_ce_o, 0);
    @(negedge clk_i); #2;
    rst_ni = 1'b0; #1;
    check("R8 idle async cpu_ce", cpu_ce_o, 1);
    check("R8 idle async ctrl", ctrl_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_run_pins;
    ext_mem_i = 1'b1; ale_i = 1'b1; psen_i = 1'b0; #1;
    check("R9 run ale", ale_o, 1);
    check("R9 run psen", psen_o, 0);
    ale_i = 1'b0; psen_i = 1'b1; #1;
    check("R9 run pass", {ale_o, psen_o}, 2'b01);
    check("R10 run", {p0_float_o, p2_addr_o}, 0);
  endtask

  initial begin
    t_reset();
    t_idle_wake();
    t_flags_locked();
    t_pdown();
    t_both();
    t_idle_reset();
    t_run_pins();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule